// File: doc/BRIEF.md
# Single-Precision Vector Min/Max Reducer

This block takes one 32-bit vector instruction word and a 128-bit operand. The operand holds four single-precision lanes. When the word is one of the across-lanes floating-point extremum instructions, the block folds the four lanes into one scalar result. There are four operations: the largest value, the smallest value, and a "numeric" form of each. The numeric form lets a number win over a quiet NaN.

The block decodes the word, evaluates a fixed two-level comparison tree and registers the result. The result comes out one clock after the strobe, together with the destination register index taken from the word. A reserved form of the encoding raises an undefined-instruction flag and produces no result. A word outside the family leaves both flags low. The caller places the scalar in the low lane of the destination and zero-fills the other lanes. Lane k of the operand is bits 32k+31 down to 32k.

Top module: `fp_lane_extremum`

## Requirements
- R1: The word is recognised when bit 31 = 0, bits 29:24 = 101110 and bits 21:16 = 110000. Bits 15:10 = 111110 select the plain form. Bits 15:10 = 110010 select the numeric form.
- R2: Bit 23 = 0 selects the maximum and bit 23 = 1 selects the minimum. Ordinary values compare by numeric value, and infinities are the extremes.
- R3: A recognised word with bit 30 = 0 or bit 22 = 1 is reserved. One clock after the strobe it raises `undef_o`, and `res_valid_o` stays low.
- R4: A word that is not recognised, or a cycle with `in_valid` low, raises neither `res_valid_o` nor `undef_o` on the next clock.
- R5: In the plain form, a comparison with any NaN input (quiet or signalling) yields 0x7FC00000.
- R6: In the numeric form, when exactly one input of a comparison is a quiet NaN, the other input is returned. When both inputs are NaN, or either is a signalling NaN, the comparison yields 0x7FC00000.
- R7: +0 ranks above -0. The maximum of the two zeros is 0x00000000 and the minimum is 0x80000000.
- R8: The reduction order is fixed. lo = op(lane0, lane1), hi = op(lane2, lane3), result = op(lo, hi).
- R9: A valid result appears on `result_o` with `res_valid_o` high exactly one clock after the strobe. `dest_o` carries bits 4:0 of the word.
- R10: Whenever `res_valid_o` is low, `result_o` and `dest_o` read zero. This includes the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: the word and operand are present |
| insn_i | input | 32 | Instruction word |
| vec_i | input | 128 | Four single-precision lanes |
| res_valid_o | output | 1 | Registered result is valid |
| undef_o | output | 1 | Reserved encoding seen |
| result_o | output | 32 | Reduced scalar |
| dest_o | output | 5 | Destination register index |

## Verification
The bench builds the block with its default default-NaN value, 0x7FC00000. The checks therefore compare NaN outcomes against that exact pattern and can detect a propagated payload. The lane data mixes ordinary numbers, signed zeros, infinities and both NaN kinds. One operand is chosen so that the fixed pairing gives a number, while a linear fold or a different lane pairing would give the default NaN or a different value. That makes the reduction order visible at the ports.

// File: rtl/fp_lane_extremum.sv
module fp_lane_extremum #(
  parameter logic [31:0] DEFAULT_NAN = 32'h7FC0_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  insn_i,
  input  logic [127:0] vec_i,
  output logic         res_valid_o,
  output logic         undef_o,
  output logic [31:0]  result_o,
  output logic [4:0]   dest_o
);

  function automatic logic [31:0] pick(input logic [31:0] a, input logic [31:0] b,
                                       input logic take_min, input logic numeric);
    logic a_nan, b_nan, a_sig, b_sig, a_gt;
    logic [31:0] ka, kb;
    a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
    b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 23'd0);
    a_sig = a_nan && !a[22];
    b_sig = b_nan && !b[22];
    ka = a[31] ? ~a : {1'b1, a[30:0]};
    kb = b[31] ? ~b : {1'b1, b[30:0]};
    a_gt = ka > kb;
    if (a_nan || b_nan) begin
      if (numeric && !a_sig && !b_sig && !(a_nan && b_nan))
        pick = a_nan ? b : a;
      else
        pick = DEFAULT_NAN;
    end else begin
      pick = (a_gt ^ take_min) ? a : b;
    end
  endfunction

  logic        hit, reserved, numeric, take_min, unused_src;
  logic [31:0] lo, hi, folded;

  assign hit = !insn_i[31] && insn_i[29:24] == 6'b101110 && insn_i[21:16] == 6'b110000 &&
               (insn_i[15:10] == 6'b110010 || insn_i[15:10] == 6'b111110);
  assign reserved   = !insn_i[30] || insn_i[22];
  assign numeric    = insn_i[15:10] == 6'b110010;
  assign take_min   = insn_i[23];
  assign unused_src = ^insn_i[9:5];

  assign lo     = pick(vec_i[31:0],  vec_i[63:32],  take_min, numeric);
  assign hi     = pick(vec_i[95:64], vec_i[127:96], take_min, numeric);
  assign folded = pick(lo, hi, take_min, numeric);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      undef_o     <= 1'b0;
      result_o    <= '0;
      dest_o      <= '0;
    end else begin
      res_valid_o <= in_valid && hit && !reserved;
      undef_o     <= in_valid && hit && reserved;
      result_o    <= (in_valid && hit && !reserved) ? folded : '0;
      dest_o      <= (in_valid && hit && !reserved) ? insn_i[4:0] : '0;
    end
  end

endmodule

// File: rtl/fp_lane_extremum_chk.sv
module fp_lane_extremum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        res_valid_o,
  input logic        undef_o,
  input logic [31:0] result_o,
  input logic [4:0]  dest_o
);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid_o && undef_o));

  assert_quiet_without_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid_o && !undef_o);

  assert_nan_is_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && result_o[30:23] == 8'hFF && result_o[22:0] != 23'd0)
      |-> result_o == 32'h7FC0_0000);

  assert_one_cycle_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(in_valid));

  assert_idle_outputs_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> result_o == 32'd0 && dest_o == 5'd0);

endmodule

bind fp_lane_extremum fp_lane_extremum_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_valid_o(res_valid_o),
  .undef_o(undef_o), .result_o(result_o), .dest_o(dest_o)
);

// File: tb/test_fp_lane_extremum.sv
`timescale 1ns/1ps
module test_fp_lane_extremum;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  insn_i = '0;
  logic [127:0] vec_i = '0;
  logic         res_valid_o, undef_o;
  logic [31:0]  result_o;
  logic [4:0]   dest_o;
  int n_checks = 0;
  int n_fail = 0;

  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000, NEG3 = 32'hC040_0000;
  localparam logic [31:0] F5P5 = 32'h40B0_0000, NEGH = 32'hBF00_0000, PZ = 32'h0, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC1_2345, SN = 32'h7F80_0001, PINF = 32'h7F80_0000;
  localparam logic [31:0] NINF = 32'hFF80_0000, DN = 32'h7FC0_0000;

  always #2 clk = ~clk;

  fp_lane_extremum i_fp_lane_extremum (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn_i(insn_i), .vec_i(vec_i),
    .res_valid_o(res_valid_o), .undef_o(undef_o), .result_o(result_o), .dest_o(dest_o)
  );

  function automatic logic [31:0] enc(input logic q, input logic mn, input logic sz,
                                      input logic num, input logic [4:0] d);
    return {1'b0, q, 6'b101110, mn, sz, 6'b110000, num ? 6'b110010 : 6'b111110, 5'd7, d};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] l0, input logic [31:0] l1,
                       input logic [31:0] l2, input logic [31:0] l3, input logic strobe);
    @(negedge clk);
    insn_i = w; vec_i = {l3, l2, l1, l0}; in_valid = strobe;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_result(input string req, input logic [31:0] v, input logic [4:0] d);
    check({req, " valid"}, {31'd0, res_valid_o}, 32'd1);
    check({req, " undef"}, {31'd0, undef_o}, 32'd0);
    check({req, " result"}, result_o, v);
    check({req, " dest"}, {27'd0, dest_o}, {27'd0, d});
  endtask

  task automatic t_reset();
    check("R10 reset valid", {31'd0, res_valid_o}, 32'd0);
    check("R10 reset undef", {31'd0, undef_o}, 32'd0);
    check("R10 reset result", result_o, 32'd0);
  endtask

  task automatic t_ordinary();
    issue(enc(1, 0, 0, 0, 5'd3), ONE, NEG3, F5P5, NEGH, 1);
    expect_result("R1 R2 plain max", F5P5, 5'd3);
    issue(enc(1, 1, 0, 0, 5'd17), ONE, NEG3, F5P5, NEGH, 1);
    expect_result("R1 R2 plain min", NEG3, 5'd17);
    issue(enc(1, 0, 0, 1, 5'd31), NEGH, ONE, NEG3, TWO, 1);
    expect_result("R1 R2 numeric max", TWO, 5'd31);
    issue(enc(1, 1, 0, 1, 5'd0), PINF, NEGH, NINF, ONE, 1);
    expect_result("R2 numeric min inf", NINF, 5'd0);
    @(negedge clk);
    check("R9 valid drops after one clock", {31'd0, res_valid_o}, 32'd0);
    check("R10 idle result zero", result_o, 32'd0);
  endtask

  task automatic t_reserved();
    issue(enc(0, 0, 0, 0, 5'd4), ONE, TWO, ONE, TWO, 1);
    check("R3 q0 undef", {31'd0, undef_o}, 32'd1);
    check("R3 q0 no valid", {31'd0, res_valid_o}, 32'd0);
    check("R10 q0 result zero", result_o, 32'd0);
    issue(enc(1, 1, 1, 1, 5'd4), ONE, TWO, ONE, TWO, 1);
    check("R3 sz1 undef", {31'd0, undef_o}, 32'd1);
    check("R3 sz1 no valid", {31'd0, res_valid_o}, 32'd0);
  endtask

  task automatic t_unmatched();
    logic [31:0] w;
    w = enc(1, 0, 0, 0, 5'd2); w[15:10] = 6'b111111;
    issue(w, ONE, TWO, ONE, TWO, 1);
    check("R4 bad op valid", {31'd0, res_valid_o}, 32'd0);
    check("R4 bad op undef", {31'd0, undef_o}, 32'd0);
    w = enc(0, 0, 0, 0, 5'd2); w[31] = 1'b1;
    issue(w, ONE, TWO, ONE, TWO, 1);
    check("R4 bit31 undef", {31'd0, undef_o}, 32'd0);
    check("R4 bit31 valid", {31'd0, res_valid_o}, 32'd0);
    issue(enc(1, 0, 0, 0, 5'd2), ONE, TWO, ONE, TWO, 0);
    check("R4 no strobe valid", {31'd0, res_valid_o}, 32'd0);
    check("R10 no strobe dest", {27'd0, dest_o}, 32'd0);
  endtask

  task automatic t_plain_nan();
    issue(enc(1, 0, 0, 0, 5'd9), ONE, TWO, QN, NEG3, 1);
    expect_result("R5 plain max qnan", DN, 5'd9);
    issue(enc(1, 1, 0, 0, 5'd9), SN, TWO, ONE, NEG3, 1);
    expect_result("R5 plain min snan", DN, 5'd9);
  endtask

  task automatic t_numeric_nan();
    issue(enc(1, 0, 0, 1, 5'd12), QN, ONE, NEG3, TWO, 1);
    expect_result("R6 numeric max skips qnan", TWO, 5'd12);
    issue(enc(1, 1, 0, 1, 5'd12), QN, QN, QN, QN, 1);
    expect_result("R6 numeric all qnan", DN, 5'd12);
    issue(enc(1, 1, 0, 1, 5'd12), SN, SN, SN, SN, 1);
    expect_result("R6 numeric all snan", DN, 5'd12);
  endtask

  task automatic t_zeros();
    issue(enc(1, 0, 0, 0, 5'd1), NZ, PZ, NZ, NZ, 1);
    expect_result("R7 max zeros", PZ, 5'd1);
    issue(enc(1, 1, 0, 1, 5'd1), PZ, PZ, NZ, PZ, 1);
    expect_result("R7 min zeros", NZ, 5'd1);
  endtask

  task automatic t_order();
    issue(enc(1, 0, 0, 1, 5'd20), ONE, TWO, QN, SN, 1);
    expect_result("R8 tree order max", TWO, 5'd20);
    issue(enc(1, 1, 0, 1, 5'd21), TWO, ONE, SN, F5P5, 1);
    expect_result("R8 tree order min", ONE, 5'd21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_ordinary();
    t_reserved();
    t_unmatched();
    t_plain_nan();
    t_numeric_nan();
    t_zeros();
    t_order();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule